// File: doc/BRIEF.md
# I/O Sense and Strobe Unit

This unit sits between the microcode decoder of a bit-serial processor and its peripherals. A microinstruction carries a 4-bit miscellaneous operation code and a 3-bit device-select field. When the operation is "sense", the unit picks one peripheral condition line with the select field and stores its value at the end of the microinstruction. The following microinstruction can then branch on the stored flag. A microsequencer that branches when the flag is false uses this to build a wait loop. When the operation is "pulse", the unit raises one strobe line, chosen by the select field, during the late half of the last bit time of the word (bit time 17).

The stored flag is kept by a two-state machine with the states HELD_FALSE and HELD_TRUE. One transition, LOAD, happens at a sense slot: this is the late half of bit time 17 while the operation is "sense". At LOAD the next state is HELD_TRUE when the selected condition is 1 and HELD_FALSE when it is 0. At every other cycle the transition is STAY and the state does not change. Reset forces HELD_FALSE. The strobes are decoded without storage from the current operation, select field and bit-time slot.

One clock cycle is one half of a bit time. The timing generator supplies the bit-time index and a flag that marks the late half.

Top module: `iosu_top`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `cond_rdy` is 0.
- R2: A sense slot is a cycle with `misc_op` = 4'b0110, `bit_idx` = 17 and `late_half` = 1. At the clock edge that ends a sense slot, the selected condition is stored. `cond_rdy` shows it from the next cycle.
- R3: The select codes for the device conditions are 3'b000 for boot-device-finished (`boot_done`), 3'b010 for teleprinter-ready (`tty_ready`), 3'b100 for tape-reader-ready (`tape_ready`) and 3'b110 for boot-data-ready (`boot_ready`).
- R4: Select code 3'b001 stores the inverse of `dial_busy`, which means dialling has finished. Select code 3'b101 stores `dial_pulse`.
- R5: Select codes 3'b011 and 3'b111 store 0.
- R6: Outside a sense slot, `cond_rdy` does not change. This holds at other bit times, in the early half of bit 17, and for any other operation code, whatever the condition lines do.
- R7: A strobe is high only while `misc_op` = 4'b1010, `bit_idx` = 17 and `late_half` = 1. In that window, select 3'b000 drives `stb_boot_start`, 3'b010 drives `stb_tty_out`, 3'b100 drives `stb_tape_ack` and 3'b110 drives `stb_boot_ack`.
- R8: At most one strobe is high at any time. Odd select codes raise no strobe.
- R9: No strobe is raised when `misc_op` is any value other than 4'b1010.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Half-bit clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| misc_op | input | 4 | Miscellaneous operation code of the current microinstruction |
| dev_sel | input | 3 | Device-select field |
| bit_idx | input | 5 | Bit-time index, 0 to 17 |
| late_half | input | 1 | High during the second half of the bit time |
| boot_done | input | 1 | Boot device has finished |
| tty_ready | input | 1 | Teleprinter can accept a character |
| tape_ready | input | 1 | Tape reader has data |
| boot_ready | input | 1 | Boot device has data |
| dial_busy | input | 1 | Dial is away from its home position |
| dial_pulse | input | 1 | A dial pulse is present |
| cond_rdy | output | 1 | Stored condition, used for branching |
| stb_boot_start | output | 1 | Start strobe for the boot device |
| stb_tty_out | output | 1 | Character-available strobe for the teleprinter |
| stb_tape_ack | output | 1 | Acknowledge strobe for the tape reader |
| stb_boot_ack | output | 1 | Acknowledge strobe for the boot device |

## Verification
A wrong stored state shows on `cond_rdy` in the cycle right after the sense slot. The bench checks that cycle for every select code against every one of the 64 patterns of the condition lines. A state that changes outside a sense slot would show one cycle after the stray edge. The bench follows each load with non-slot cycles that drive the inverted condition pattern, so such a change is caught there. Strobe errors need no state and show in the same cycle, so the bench sweeps every combination of operation, select code, bit time and half.

// File: rtl/iosu_pkg.sv
package iosu_pkg;
    localparam logic [3:0] OP_SENSE = 4'b0110;
    localparam logic [3:0] OP_PULSE = 4'b1010;

    typedef enum logic {
        HELD_FALSE = 1'b0,
        HELD_TRUE  = 1'b1
    } hold_state_t;

    typedef struct packed {
        logic boot_done;
        logic tty_ready;
        logic tape_ready;
        logic boot_ready;
        logic dial_busy;
        logic dial_pulse;
    } sense_lines_t;
endpackage

// File: rtl/iosu_slot.sv
module iosu_slot
    import iosu_pkg::*;
#(
    parameter int BIT_W    = 5,
    parameter int LAST_BIT = 17
) (
    input  logic [3:0]       misc_op,
    input  logic [BIT_W-1:0] bit_idx,
    input  logic             late_half,
    output logic             sense_now,
    output logic             pulse_now
);
    logic final_half;

    always_comb begin
        final_half = late_half && (bit_idx == BIT_W'(LAST_BIT));
        sense_now  = final_half && (misc_op == OP_SENSE);
        pulse_now  = final_half && (misc_op == OP_PULSE);
    end
endmodule

// File: rtl/iosu_cond_mux.sv
module iosu_cond_mux
    import iosu_pkg::*;
#(
    parameter int SEL_W = 3
) (
    input  sense_lines_t     lines,
    input  logic [SEL_W-1:0] dev_sel,
    output logic             picked
);
    always_comb begin
        unique case (dev_sel)
            3'b000:  picked = lines.boot_done;
            3'b010:  picked = lines.tty_ready;
            3'b100:  picked = lines.tape_ready;
            3'b110:  picked = lines.boot_ready;
            3'b001:  picked = !lines.dial_busy;
            3'b101:  picked = lines.dial_pulse;
            default: picked = 1'b0;
        endcase
    end
endmodule

// File: rtl/iosu_strobe_dec.sv
module iosu_strobe_dec #(
    parameter int SEL_W = 3,
    parameter int N_STB = 4
) (
    input  logic             fire,
    input  logic [SEL_W-1:0] dev_sel,
    output logic [N_STB-1:0] stb
);
    localparam int CODE_W = SEL_W - 1;

    for (genvar g = 0; g < N_STB; g++) begin : g_stb
        assign stb[g] = fire && !dev_sel[0] && (dev_sel[SEL_W-1:1] == CODE_W'(g));
    end
endmodule

// File: rtl/iosu_top.sv
module iosu_top
    import iosu_pkg::*;
#(
    parameter int BIT_W    = 5,
    parameter int LAST_BIT = 17,
    parameter int SEL_W    = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [3:0]       misc_op,
    input  logic [SEL_W-1:0] dev_sel,
    input  logic [BIT_W-1:0] bit_idx,
    input  logic             late_half,
    input  logic             boot_done,
    input  logic             tty_ready,
    input  logic             tape_ready,
    input  logic             boot_ready,
    input  logic             dial_busy,
    input  logic             dial_pulse,
    output logic             cond_rdy,
    output logic             stb_boot_start,
    output logic             stb_tty_out,
    output logic             stb_tape_ack,
    output logic             stb_boot_ack
);
    localparam int N_STB = 4;

    sense_lines_t     lines;
    logic             sense_now;
    logic             pulse_now;
    logic             picked;
    logic [N_STB-1:0] stb;
    hold_state_t      state_q;
    hold_state_t      state_d;

    assign lines = '{boot_done:  boot_done,
                     tty_ready:  tty_ready,
                     tape_ready: tape_ready,
                     boot_ready: boot_ready,
                     dial_busy:  dial_busy,
                     dial_pulse: dial_pulse};

    iosu_slot #(.BIT_W(BIT_W), .LAST_BIT(LAST_BIT)) i_slot (
        .misc_op   (misc_op),
        .bit_idx   (bit_idx),
        .late_half (late_half),
        .sense_now (sense_now),
        .pulse_now (pulse_now)
    );

    iosu_cond_mux #(.SEL_W(SEL_W)) i_mux (
        .lines   (lines),
        .dev_sel (dev_sel),
        .picked  (picked)
    );

    iosu_strobe_dec #(.SEL_W(SEL_W), .N_STB(N_STB)) i_dec (
        .fire    (pulse_now),
        .dev_sel (dev_sel),
        .stb     (stb)
    );

    // Next state: LOAD at a sense slot, STAY otherwise
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            HELD_FALSE: if (sense_now && picked)  state_d = HELD_TRUE;
            HELD_TRUE:  if (sense_now && !picked) state_d = HELD_FALSE;
            default:    state_d = HELD_FALSE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= HELD_FALSE;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            HELD_TRUE: cond_rdy = 1'b1;
            default:   cond_rdy = 1'b0;
        endcase
        stb_boot_start = stb[0];
        stb_tty_out    = stb[1];
        stb_tape_ack   = stb[2];
        stb_boot_ack   = stb[3];
    end

    AST_RESET_LOW: assert property (@(posedge clk) !rst_n |=> !cond_rdy); // R1
    AST_LOAD_PICKED: assert property (@(posedge clk) disable iff (!rst_n)
        sense_now |=> cond_rdy == $past(picked)); // R2
    AST_HOLD_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        !sense_now |=> $stable(cond_rdy)); // R6
    AST_STROBE_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        (|stb) |-> (misc_op == OP_PULSE && late_half && bit_idx == BIT_W'(LAST_BIT))); // R7
    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(stb)); // R8
    AST_ODD_SEL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        dev_sel[0] |-> !(|stb)); // R8
endmodule

// File: tb/test_iosu_top.sv
module test_iosu_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] misc_op = 4'd0;
    logic [2:0] dev_sel = 3'd0;
    logic [4:0] bit_idx = 5'd0;
    logic       late_half = 1'b0;
    logic [5:0] cond = 6'd0;
    logic       cond_rdy, stb_boot_start, stb_tty_out, stb_tape_ack, stb_boot_ack;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    iosu_top i_iosu_top (
        .clk(clk), .rst_n(rst_n), .misc_op(misc_op), .dev_sel(dev_sel),
        .bit_idx(bit_idx), .late_half(late_half),
        .boot_done(cond[0]), .tty_ready(cond[1]), .tape_ready(cond[2]),
        .boot_ready(cond[3]), .dial_busy(cond[4]), .dial_pulse(cond[5]),
        .cond_rdy(cond_rdy), .stb_boot_start(stb_boot_start), .stb_tty_out(stb_tty_out),
        .stb_tape_ack(stb_tape_ack), .stb_boot_ack(stb_boot_ack)
    );

    function automatic logic exp_cond(input logic [2:0] s, input logic [5:0] c);
        case (s)
            3'd0: return c[0];
            3'd2: return c[1];
            3'd4: return c[2];
            3'd6: return c[3];
            3'd1: return !c[4];
            3'd5: return c[5];
            default: return 1'b0;
        endcase
    endfunction

    task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    // drive at negedge, the posedge in between latches, result seen at next negedge
    task automatic cycle(input logic [3:0] op, input logic [2:0] s, input logic [4:0] b,
                         input logic h, input logic [5:0] c);
        misc_op = op; dev_sel = s; bit_idx = b; late_half = h; cond = c;
        @(negedge clk);
    endtask

    initial begin
        @(negedge clk);
        check("R1", {3'b0, cond_rdy}, 4'b0);
        @(negedge clk);
        rst_n = 1'b1;
        check("R1", {3'b0, cond_rdy}, 4'b0);

        // load sweep: every select code against every condition pattern
        for (int p = 0; p < 64; p++) begin
            for (int s = 0; s < 8; s++) begin
                logic e;
                string tag;
                e = exp_cond(3'(s), 6'(p));
                if (s == 1 || s == 5)      tag = "R4";
                else if (s == 3 || s == 7) tag = "R5";
                else                       tag = "R3";
                cycle(4'b0110, 3'(s), 5'd17, 1'b1, 6'(p));
                check({"R2 ", tag}, {3'b0, cond_rdy}, {3'b0, e});
                cycle(4'b0110, 3'(s), 5'd17, 1'b0, ~6'(p));
                check("R6 early half", {3'b0, cond_rdy}, {3'b0, e});
                cycle(4'b0110, 3'(s), 5'(p % 17), 1'b1, ~6'(p));
                check("R6 other bit", {3'b0, cond_rdy}, {3'b0, e});
                cycle(4'b1010, 3'(s), 5'd17, 1'b1, ~6'(p));
                check("R6 other op", {3'b0, cond_rdy}, {3'b0, e});
            end
        end

        // strobe sweep over op, select, bit time and half
        for (int op = 0; op < 16; op++) begin
            for (int s = 0; s < 8; s++) begin
                for (int b = 0; b < 18; b++) begin
                    for (int h = 0; h < 2; h++) begin
                        logic [3:0] e;
                        misc_op = 4'(op); dev_sel = 3'(s); bit_idx = 5'(b); late_half = h[0];
                        #1;
                        e = 4'b0;
                        if (op == 10 && b == 17 && h == 1 && s % 2 == 0) e = 4'(1 << (s / 2));
                        if (op != 10)
                            check("R9", {stb_boot_ack, stb_tape_ack, stb_tty_out, stb_boot_start}, e);
                        else if (s % 2 == 1)
                            check("R8", {stb_boot_ack, stb_tape_ack, stb_tty_out, stb_boot_start}, e);
                        else
                            check("R7", {stb_boot_ack, stb_tape_ack, stb_tty_out, stb_boot_start}, e);
                    end
                end
            end
        end

        // reset clears a held true flag
        @(negedge clk);
        cycle(4'b0110, 3'd2, 5'd17, 1'b1, 6'b000010);
        check("R2", {3'b0, cond_rdy}, 4'b1);
        rst_n = 1'b0;
        #1;
        check("R1", {3'b0, cond_rdy}, 4'b0);
        @(negedge clk);
        rst_n = 1'b1;
        cycle(4'd0, 3'd0, 5'd0, 1'b0, 6'd0);
        check("R1", {3'b0, cond_rdy}, 4'b0);

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule